// File: doc/BRIEF.md
# Status Byte and Write-Permission Guard

This block keeps the one-byte status word of a serial nonvolatile memory and decides, at every moment, whether a write to the storage array or to the status word itself may proceed. It sits between the serial command front-end, which reports decoded events as single-cycle pulses, and the programming sequencer, which reports when an internal write cycle is running and when it finishes.

The status word carries a hardware-protect enable, a two-bit block-protect level, the write-enable latch and the busy flag. The block-protect level fences off the top quarter, the top half or all of the array. The external write-protect pin, combined with the protect enable, locks the status word against change. Status writes are staged at the end of their data byte. They are released only when the select closes cleanly, and they land in the protect bits when the sequencer signals completion. The protect bits are held in a plain register that stands in for nonvolatile cells.

Top module: `status_guard`

## Requirements
- R1: `status_byte` reads bit 7 = protect enable, bits 6..4 = 0, bit 3 = block-protect high bit, bit 2 = block-protect low bit, bit 1 = write-enable latch, bit 0 = `busy_in`.
- R2: After reset the protect enable, both block-protect bits and the write-enable latch are 0.
- R3: The latch is set only when an `op_wren` is followed by `sel_end` with no `bit_ev`, `sel_start` or other opcode in between.
- R4: An `op_wrdi` while not busy clears the latch on the next cycle.
- R5: An `arr_done` or `sr_done` pulse clears the latch on the next cycle.
- R6: The block-protect level 0/1/2/3 protects no address, the addresses whose two top bits are 11, the addresses whose top bit is 1, and every address; `arr_wr_permit` is 0 for a protected address whatever the pin or the protect enable.
- R7: `arr_wr_permit` is 1 only when the latch is 1, `busy_in` is 0 and the address is unprotected.
- R8: `sr_wr_permit` pulses during `sel_end` only if a status data byte was taken in the same select, no `bit_ev` came after it, the latch is 1, and hardware protection (`wp_pin` low with protect enable 1) is not in force.
- R9: If hardware protection comes into force at any time between the status data byte and `sel_end`, that status write is not permitted.
- R10: A permitted status write changes only bits 7, 3 and 2, and only on `sr_done`; a change of `wp_pin` after the permit has no effect on it.
- R11: While `busy_in` is 1, `op_wren`, `op_wrdi` and `sr_data_valid` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| wp_pin | input | 1 | Write-protect pin level, low = protect request |
| sel_start | input | 1 | Pulse: chip select asserted |
| sel_end | input | 1 | Pulse: chip select released |
| bit_ev | input | 1 | Pulse: one serial bit received |
| op_wren | input | 1 | Pulse: write-enable opcode decoded |
| op_wrdi | input | 1 | Pulse: write-disable opcode decoded |
| sr_data_valid | input | 1 | Pulse: status-write data byte complete |
| sr_data | input | 8 | Status-write data byte |
| busy_in | input | 1 | Internal write cycle running |
| arr_done | input | 1 | Pulse: array write cycle finished |
| sr_done | input | 1 | Pulse: status write cycle finished |
| wr_addr | input | ADDR_W | Target array address |
| status_byte | output | 8 | Status word for reading |
| arr_wr_permit | output | 1 | Array write at `wr_addr` allowed |
| sr_wr_permit | output | 1 | Status write allowed (pulse with `sel_end`) |

## Verification
The bench builds the block with ADDR_W = 14, a 16K-byte array, so the quarter and half fences fall at 0x3000 and 0x2000 and the addresses on either side of each boundary can be probed directly. The width is small enough that the bench computes the fence positions from the array size by integer arithmetic instead of taking them from the address bits. Directed sequences drive the pin through the cases the truth table distinguishes: low before the data byte, a short low pulse inside the pending window, and a drop after the permit.

// File: rtl/status_guard_pkg.sv
package status_guard_pkg;
  localparam int SB_WPEN = 7;
  localparam int SB_BP1  = 3;
  localparam int SB_BP0  = 2;
  localparam int SB_WEL  = 1;
  localparam int SB_BUSY = 0;

  typedef enum logic [1:0] {
    PROT_NONE = 2'd0,
    PROT_QTR  = 2'd1,
    PROT_HALF = 2'd2,
    PROT_ALL  = 2'd3
  } prot_lvl_t;

  // top2 = the two most significant address bits
  function automatic logic blk_hit(prot_lvl_t lvl, logic [1:0] top2);
    case (lvl)
      PROT_NONE: return 1'b0;
      PROT_QTR:  return (top2 == 2'b11);
      PROT_HALF: return top2[1];
      default:   return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/sg_blk_decode.sv
module sg_blk_decode
  import status_guard_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic [ADDR_W-1:0] addr,
  input  prot_lvl_t         lvl,
  output logic              prot
);
  localparam int TOP = ADDR_W - 1;

  assign prot = blk_hit(lvl, addr[TOP -: 2]);

  always_comb begin
    assert_none_open_R6: assert (!(lvl == PROT_NONE && prot));
    assert_all_closed_R6: assert (!(lvl == PROT_ALL && !prot));
  end
endmodule

// File: rtl/sg_wel_latch.sv
module sg_wel_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_start,
  input  logic sel_end,
  input  logic bit_ev,
  input  logic op_wren,
  input  logic op_wrdi,
  input  logic busy,
  input  logic wr_done,
  output logic wel
);
  logic wren_pend;
  logic set_ev, clr_ev;

  assign set_ev = sel_end && wren_pend;
  assign clr_ev = wr_done || (op_wrdi && !busy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wren_pend <= 1'b0;
    else if (op_wren && !busy) wren_pend <= 1'b1;
    else if (sel_start || sel_end || bit_ev || op_wrdi || op_wren) wren_pend <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wel <= 1'b0;
    else if (clr_ev) wel <= 1'b0;
    else if (set_ev) wel <= 1'b1;
  end

  assert_wel_set_only_on_close_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wel && !(sel_end && wren_pend) |=> !wel);
  assert_wrdi_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    op_wrdi && !busy |=> !wel);
  assert_done_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !wel);
  assert_busy_blocks_wren_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !wren_pend |=> !wren_pend);
endmodule

// File: rtl/sg_sr_stage.sv
module sg_sr_stage
  import status_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_start,
  input  logic       sel_end,
  input  logic       bit_ev,
  input  logic       sr_data_valid,
  input  logic [7:0] sr_data,
  input  logic       hw_prot,
  input  logic       wel,
  input  logic       busy,
  input  logic       sr_done,
  output logic       sr_permit,
  output logic       wpen,
  output prot_lvl_t  lvl
);
  logic       take_ev, commit_ev;
  logic       sr_pend, sr_armed;
  logic [7:0] staged;

  assign take_ev   = sr_data_valid && !busy && !sr_armed;
  assign sr_permit = sel_end && sr_pend && wel && !hw_prot;
  assign commit_ev = sr_done && sr_armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_pend <= 1'b0;
      staged  <= 8'h00;
    end else if (take_ev) begin
      sr_pend <= 1'b1;
      staged  <= sr_data;
    end else if (sel_start || sel_end || bit_ev || hw_prot) begin
      sr_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_armed <= 1'b0;
    else if (commit_ev) sr_armed <= 1'b0;
    else if (sr_permit) sr_armed <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wpen <= 1'b0;
      lvl  <= PROT_NONE;
    end else if (commit_ev) begin
      wpen <= staged[SB_WPEN];
      lvl  <= prot_lvl_t'({staged[SB_BP1], staged[SB_BP0]});
    end
  end

  assert_hwp_cancels_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hw_prot && !take_ev |=> !sr_permit);
  assert_bits_change_on_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_ev |=> $stable(wpen) && $stable(lvl));
  assert_busy_blocks_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !sr_pend |=> !sr_pend);
endmodule

// File: rtl/status_guard.sv
module status_guard
  import status_guard_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_pin,
  input  logic              sel_start,
  input  logic              sel_end,
  input  logic              bit_ev,
  input  logic              op_wren,
  input  logic              op_wrdi,
  input  logic              sr_data_valid,
  input  logic [7:0]        sr_data,
  input  logic              busy_in,
  input  logic              arr_done,
  input  logic              sr_done,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        status_byte,
  output logic              arr_wr_permit,
  output logic              sr_wr_permit
);
  logic      wel, wpen, hw_prot, addr_prot;
  prot_lvl_t lvl;

  assign hw_prot = !wp_pin && wpen;

  sg_wel_latch u_wel (
    .clk(clk), .rst_n(rst_n), .sel_start(sel_start), .sel_end(sel_end),
    .bit_ev(bit_ev), .op_wren(op_wren), .op_wrdi(op_wrdi), .busy(busy_in),
    .wr_done(arr_done || sr_done), .wel(wel)
  );

  sg_sr_stage u_stage (
    .clk(clk), .rst_n(rst_n), .sel_start(sel_start), .sel_end(sel_end),
    .bit_ev(bit_ev), .sr_data_valid(sr_data_valid), .sr_data(sr_data),
    .hw_prot(hw_prot), .wel(wel), .busy(busy_in), .sr_done(sr_done),
    .sr_permit(sr_wr_permit), .wpen(wpen), .lvl(lvl)
  );

  sg_blk_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(wr_addr), .lvl(lvl), .prot(addr_prot)
  );

  always_comb begin
    status_byte          = 8'h00;
    status_byte[SB_WPEN] = wpen;
    status_byte[SB_BP1]  = lvl[1];
    status_byte[SB_BP0]  = lvl[0];
    status_byte[SB_WEL]  = wel;
    status_byte[SB_BUSY] = busy_in;
  end

  assign arr_wr_permit = wel && !busy_in && !addr_prot;

  assert_arr_needs_wel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr_permit |-> status_byte[SB_WEL] && !busy_in);
  assert_sr_needs_wel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr_permit |-> wel && sel_end);
endmodule

// File: tb/tb_status_guard.sv
module tb_status_guard;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 14;
  localparam int ASIZE  = 1 << ADDR_W;

  logic clk = 0, rst_n = 0;
  logic wp_pin = 1, sel_start = 0, sel_end = 0, bit_ev = 0, op_wren = 0, op_wrdi = 0;
  logic sr_data_valid = 0, busy_in = 0, arr_done = 0, sr_done = 0;
  logic [7:0] sr_data = 0;
  logic [ADDR_W-1:0] wr_addr = 0;
  logic [7:0] status_byte;
  logic arr_wr_permit, sr_wr_permit;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  status_guard #(.ADDR_W(ADDR_W)) dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1;
    @(negedge clk); s = 0;
  endtask

  task automatic wren_cmd();
    pulse(sel_start); pulse(op_wren); pulse(sel_end);
  endtask

  // expected protection from the array size, independent of address slicing
  function automatic bit exp_prot(int lvl, int a);
    case (lvl)
      0: return 0;
      1: return a >= (ASIZE * 3) / 4;
      2: return a >= ASIZE / 2;
      default: return 1;
    endcase
  endfunction

  task automatic probe(string tag, int lvl, int a);
    @(negedge clk); wr_addr = a[ADDR_W-1:0]; #1;
    chk(tag, arr_wr_permit, !exp_prot(lvl, a));
  endtask

  // status write; returns after sel_end, checking the permit during it
  task automatic sr_cmd(string tag, logic [7:0] d, bit drop_wp, bit exp);
    pulse(sel_start);
    sr_data = d; pulse(sr_data_valid);
    if (drop_wp) begin
      @(negedge clk); wp_pin = 0;
      @(negedge clk); wp_pin = 1;
    end
    @(negedge clk); sel_end = 1; #1;
    chk(tag, sr_wr_permit, exp);
    @(negedge clk); sel_end = 0;
    if (exp) pulse(sr_done);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R2 reset status", status_byte, 8'h00);
    busy_in = 1; #1;
    chk("R1 busy bit 0", status_byte, 8'h01);
    @(negedge clk); busy_in = 0;
  endtask

  task automatic t_wel();
    wren_cmd(); @(negedge clk);
    chk("R3 wren closed", status_byte, 8'h02);
    pulse(op_wrdi); @(negedge clk);
    chk("R4 wrdi clears", status_byte, 8'h00);
    pulse(sel_start); pulse(op_wren); pulse(bit_ev); pulse(sel_end);
    chk("R3 extra bit blocks", status_byte[1], 1'b0);
    busy_in = 1;
    pulse(sel_start); pulse(op_wren); pulse(sel_end);
    chk("R11 wren while busy", status_byte, 8'h01);
    busy_in = 0;
  endtask

  task automatic t_array();
    wr_addr = '1; @(negedge clk); #1;
    chk("R7 no wel no permit", arr_wr_permit, 1'b0);
    wren_cmd(); @(negedge clk); #1;
    chk("R7 wel permit top", arr_wr_permit, 1'b1);
    busy_in = 1; #1;
    chk("R7 busy blocks", arr_wr_permit, 1'b0);
    pulse(op_wrdi); busy_in = 0; #1;
    chk("R11 wrdi while busy", status_byte[1], 1'b1);
    pulse(arr_done); #1;
    chk("R5 arr_done clears", status_byte, 8'h00);
  endtask

  task automatic t_levels();
    sr_cmd("R8 no wel", 8'h0C, 0, 0);
    chk("R8 status unchanged", status_byte, 8'h00);
    wren_cmd();
    sr_cmd("R8 qtr permit", 8'h74, 0, 1); @(negedge clk);
    chk("R10 only 7,3,2", status_byte, 8'h04);
    chk("R5 sr_done clears", status_byte[1], 1'b0);
    wren_cmd();
    probe("R6 qtr below", 1, ASIZE*3/4 - 1);
    probe("R6 qtr at", 1, ASIZE*3/4);
    sr_cmd("R8 half permit", 8'h08, 0, 1);
    wren_cmd();
    probe("R6 half below", 2, ASIZE/2 - 1);
    probe("R6 half at", 2, ASIZE/2);
    pulse(sel_start); sr_data = 8'h0C; pulse(sr_data_valid); pulse(bit_ev);
    @(negedge clk); sel_end = 1; #1;
    chk("R8 bit after data", sr_wr_permit, 1'b0);
    @(negedge clk); sel_end = 0;
    sr_cmd("R8 full permit", 8'h0C, 0, 1);
    wren_cmd();
    probe("R6 full zero", 3, 0);
    sr_cmd("R8 enable wpen", 8'h80, 0, 1); @(negedge clk);
    chk("R1 wpen bit 7", status_byte, 8'h80);
  endtask

  task automatic t_hw();
    wp_pin = 0; wren_cmd();
    sr_cmd("R8 hw protect", 8'h00, 0, 0);
    probe("R6 unprotected under hw", 0, ASIZE - 1);
    wp_pin = 1;
    sr_cmd("R9 wp pulse cancels", 8'h00, 1, 0);
    pulse(sel_start); sr_data = 8'h0C; pulse(sr_data_valid);
    @(negedge clk); sel_end = 1; #1;
    chk("R9 clean permit", sr_wr_permit, 1'b1);
    @(negedge clk); sel_end = 0; wp_pin = 0;
    pulse(sr_done); @(negedge clk);
    chk("R10 wp after start", status_byte, 8'h0C);
    wp_pin = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_wel(); t_array(); t_levels(); t_hw();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule